// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block sits on a simple peripheral bus as a slave and opens two windows onto internal register spaces that are too large or too narrow to map directly. Each window owns three host-visible registers: an address latch, a data port and a control word. Software loads the address latch, then touches the data port. A data-port write is forwarded as one write to the internal target. A data-port read is pipelined: it fires an internal read at the latched address and stores the answer in a capture register, but hands the host the capture contents from before that fetch. Software therefore writes the address twice and reads the data port twice, and the bridge is built so that both rules are harmless and correct.

The first window reaches a 32-bit configuration space. The second reaches a controller space whose registers hold 8-bit values. Each window has an error-enable bit. When it is set, a data access the target cannot accept (address beyond the space, or a value too wide for an 8-bit register) is refused and reported with a bus error on that transfer. The bus completes every transfer in one access cycle.

Top module: `indirect_window_bridge`

## Requirements
- R1: Host offset decode: bit 4 of `paddr` picks the window (0 = configuration, 1 = controller), and bits 3:2 pick the register (0 = address latch, 1 = data port, 2 = control). Offsets with bits 1:0 or 7:5 non-zero, or bits 3:2 equal to 3, read as zero and change no state. At most one target port is requested in any cycle.
- R2: An address-latch write keeps only `pwdata[15:0]`; reading the latch returns that value with bits 31:16 zero.
- R3: Address-latch writes never issue an internal request, and writing the same address twice leaves the window in the same state as writing it once.
- R4: Each data-port read issues exactly one internal read cycle at the latched address, returns the capture register's prior contents, and loads the capture register with the target's answer.
- R5: Two data-port reads after an address write return the target's value at that address on the second read.
- R6: A data-port write issues exactly one internal write cycle carrying the latched address and the written value.
- R7: The control register keeps only bit 15 (error enable); other bits read as zero.
- R8: With error enable set, a data access to an address at or beyond the window's limit (configuration default 0x1000, controller default 0x10000) raises `pslverr` for that transfer and issues no internal request; such a read loads zero into the capture register. Address 0x0FFF in the configuration window and 0xFFFF in the controller window are in range.
- R9: With error enable clear, an out-of-range data access issues no internal request and raises no error.
- R10: `pready` is always 1, and `pslverr` is only ever high during an access cycle.
- R11: After reset the address latches, control registers and capture registers are zero.
- R12: Controller-window writes carry `pwdata[7:0]`; reads are zero-extended. A write whose bits 31:8 are non-zero is refused with `pslverr` when error enable is set, and is forwarded truncated when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete (constant 1) |
| pslverr | output | 1 | Error response |
| cfg_req | output | 1 | Configuration space request strobe |
| cfg_we | output | 1 | Configuration request is a write |
| cfg_addr | output | 16 | Configuration register address |
| cfg_wdata | output | 32 | Configuration write value |
| cfg_rdata | input | 32 | Configuration read value, same cycle |
| ctl_req | output | 1 | Controller space request strobe |
| ctl_we | output | 1 | Controller request is a write |
| ctl_addr | output | 16 | Controller register address |
| ctl_wdata | output | 8 | Controller write value |
| ctl_rdata | input | 8 | Controller read value, same cycle |

## Verification
The assertions watch every cycle for the structural rules: no internal request on an address write, an address latch that changes only on its own write, requests that never leave the permitted range, a capture register that always holds the last answer fetched, one target strobed at a time, and error responses confined to access cycles. What only the bench scenarios can show is the host-visible meaning of the two-read protocol: that the first read after an address change returns stale data and the second returns the fresh value, that refused writes really leave the target untouched, and that the two windows keep independent state.

// File: rtl/iwb_pkg.sv
package iwb_pkg;

    localparam int HOST_AW = 8;
    localparam int BUS_DW  = 32;
    localparam int TGT_AW  = 16;
    localparam int ERR_EN_BIT = 15;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic     hit_cfg;
        logic     hit_ctl;
        win_sel_e sel;
    } host_dec_t;

    function automatic host_dec_t decode_offset(input logic [HOST_AW-1:0] off);
        host_dec_t d;
        d.hit_cfg = 1'b0;
        d.hit_ctl = 1'b0;
        d.sel     = SEL_NONE;
        if (off[HOST_AW-1:5] == '0 && off[1:0] == 2'b00 && off[3:2] != 2'b11) begin
            d.sel     = win_sel_e'(off[3:2]);
            d.hit_cfg = ~off[4];
            d.hit_ctl = off[4];
        end
        return d;
    endfunction

endpackage

// File: rtl/iwb_decode.sv
module iwb_decode
    import iwb_pkg::*;
(
    input  logic               psel,
    input  logic               penable,
    input  logic [HOST_AW-1:0] paddr,
    output logic               acc_cfg,
    output logic               acc_ctl,
    output win_sel_e           sel
);
    host_dec_t dec;

    always_comb begin
        dec     = decode_offset(paddr);
        acc_cfg = psel && penable && dec.hit_cfg;
        acc_ctl = psel && penable && dec.hit_ctl;
        sel     = dec.sel;
    end

    always_comb begin
        assert_exclusive_window_R1: assert (!(acc_cfg && acc_ctl));
    end
endmodule

// File: rtl/iwb_window.sv
module iwb_window
    import iwb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIMIT  = 32'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  win_sel_e          sel,
    input  logic              we,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata,
    output logic              err,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [TGT_AW-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata
);
    localparam logic [TGT_AW:0] LIM = LIMIT[TGT_AW:0];

    logic [TGT_AW-1:0] addr_q;
    logic              err_en_q;
    logic [DATA_W-1:0] cap_q;
    logic              in_range;
    logic              too_wide;
    logic              data_acc;
    logic              refuse;
    logic [BUS_DW-1:0] cap_ext;

    generate
        if (DATA_W < BUS_DW) begin : g_narrow
            assign too_wide = |wdata[BUS_DW-1:DATA_W];
        end else begin : g_full
            assign too_wide = 1'b0;
        end
    endgenerate

    always_comb begin
        in_range = ({1'b0, addr_q} < LIM);
        data_acc = acc && (sel == SEL_DATA);
        refuse   = !in_range || (err_en_q && we && too_wide);
        tgt_req  = data_acc && !refuse;
        tgt_we   = we;
        tgt_addr = addr_q;
        tgt_wdata = wdata[DATA_W-1:0];
        err      = data_acc && err_en_q && refuse;
        cap_ext  = '0;
        cap_ext[DATA_W-1:0] = cap_q;
        case (sel)
            SEL_ADDR: rdata = {{(BUS_DW-TGT_AW){1'b0}}, addr_q};
            SEL_DATA: rdata = cap_ext;
            SEL_CTRL: rdata = BUS_DW'({err_en_q, {ERR_EN_BIT{1'b0}}});
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            err_en_q <= 1'b0;
            cap_q    <= '0;
        end else if (acc) begin
            if (we && sel == SEL_ADDR) addr_q <= wdata[TGT_AW-1:0];
            if (we && sel == SEL_CTRL) err_en_q <= wdata[ERR_EN_BIT];
            if (!we && sel == SEL_DATA) cap_q <= in_range ? tgt_rdata : '0;
        end
    end

    assert_no_req_on_addr_write_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && sel == SEL_ADDR) |-> !tgt_req);

    assert_addr_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !(acc && we && sel == SEL_ADDR) |=> $stable(tgt_addr));

    assert_capture_loads_R4: assert property (@(posedge clk) disable iff (rst)
        (tgt_req && !tgt_we) |=> (rdata == $past(cap_ext_fetch())) || (sel != SEL_DATA));

    assert_req_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        tgt_req |-> ({1'b0, tgt_addr} < LIM));

    function automatic logic [BUS_DW-1:0] cap_ext_fetch();
        logic [BUS_DW-1:0] v;
        v = '0;
        v[DATA_W-1:0] = tgt_rdata;
        return v;
    endfunction
endmodule

// File: rtl/iwb_resp_mux.sv
module iwb_resp_mux
    import iwb_pkg::*;
(
    input  logic              acc_ctl,
    input  logic [BUS_DW-1:0] rdata_cfg,
    input  logic [BUS_DW-1:0] rdata_ctl,
    input  logic              err_cfg,
    input  logic              err_ctl,
    output logic [BUS_DW-1:0] prdata,
    output logic              pslverr
);
    always_comb begin
        prdata  = acc_ctl ? rdata_ctl : rdata_cfg;
        pslverr = err_cfg || err_ctl;
    end
endmodule

// File: rtl/indirect_window_bridge.sv
module indirect_window_bridge
    import iwb_pkg::*;
#(
    parameter int CFG_LIMIT = 32'h1000,
    parameter int CTL_LIMIT = 32'h10000,
    parameter int CTL_DW    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [HOST_AW-1:0] paddr,
    input  logic [BUS_DW-1:0]  pwdata,
    output logic [BUS_DW-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    output logic               cfg_req,
    output logic               cfg_we,
    output logic [TGT_AW-1:0]  cfg_addr,
    output logic [BUS_DW-1:0]  cfg_wdata,
    input  logic [BUS_DW-1:0]  cfg_rdata,
    output logic               ctl_req,
    output logic               ctl_we,
    output logic [TGT_AW-1:0]  ctl_addr,
    output logic [CTL_DW-1:0]  ctl_wdata,
    input  logic [CTL_DW-1:0]  ctl_rdata
);
    logic              acc_cfg;
    logic              acc_ctl;
    win_sel_e          sel;
    logic [BUS_DW-1:0] rdata_cfg;
    logic [BUS_DW-1:0] rdata_ctl;
    logic              err_cfg;
    logic              err_ctl;
    logic              rd_cfg;
    logic              rd_ctl;

    assign pready = 1'b1;

    iwb_decode u_decode (
        .psel    (psel),
        .penable (penable),
        .paddr   (paddr),
        .acc_cfg (acc_cfg),
        .acc_ctl (acc_ctl),
        .sel     (sel)
    );

    iwb_window #(.DATA_W(BUS_DW), .LIMIT(CFG_LIMIT)) u_win_cfg (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc_cfg),
        .sel       (sel),
        .we        (pwrite),
        .wdata     (pwdata),
        .rdata     (rdata_cfg),
        .err       (err_cfg),
        .tgt_req   (cfg_req),
        .tgt_we    (cfg_we),
        .tgt_addr  (cfg_addr),
        .tgt_wdata (cfg_wdata),
        .tgt_rdata (cfg_rdata)
    );

    iwb_window #(.DATA_W(CTL_DW), .LIMIT(CTL_LIMIT)) u_win_ctl (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc_ctl),
        .sel       (sel),
        .we        (pwrite),
        .wdata     (pwdata),
        .rdata     (rdata_ctl),
        .err       (err_ctl),
        .tgt_req   (ctl_req),
        .tgt_we    (ctl_we),
        .tgt_addr  (ctl_addr),
        .tgt_wdata (ctl_wdata),
        .tgt_rdata (ctl_rdata)
    );

    iwb_resp_mux u_resp (
        .acc_ctl   (acc_ctl),
        .rdata_cfg (rdata_cfg),
        .rdata_ctl (rdata_ctl),
        .err_cfg   (err_cfg),
        .err_ctl   (err_ctl),
        .prdata    (prdata),
        .pslverr   (pslverr)
    );

    assign rd_cfg = cfg_req && !cfg_we;
    assign rd_ctl = ctl_req && !ctl_we;

    assert_one_target_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_req, ctl_req}));

    assert_err_in_access_R10: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (psel && penable));

    assert_read_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_cfg || rd_ctl) |-> (psel && penable && !pwrite));
endmodule

// File: tb/indirect_window_bridge_tb.sv
`timescale 1ns/1ps
module indirect_window_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        cfg_req, cfg_we, ctl_req, ctl_we;
    logic [15:0] cfg_addr, ctl_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [7:0]  ctl_wdata, ctl_rdata;

    always #4 clk = ~clk;

    indirect_window_bridge u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    // Target models: 16-entry spaces indexed by the low address bits
    logic [31:0] mem_cfg [16];
    logic [7:0]  mem_ctl [16];
    int n_cfg_rd = 0, n_cfg_wr = 0, n_ctl_rd = 0, n_ctl_wr = 0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_cfg[i] = 32'hA000_0000 + i;
            mem_ctl[i] = 8'h50 + 8'(i);
        end
    end

    assign cfg_rdata = mem_cfg[cfg_addr[3:0]];
    assign ctl_rdata = mem_ctl[ctl_addr[3:0]];

    always @(posedge clk) begin
        if (cfg_req && cfg_we) begin mem_cfg[cfg_addr[3:0]] <= cfg_wdata; n_cfg_wr++; end
        if (cfg_req && !cfg_we) n_cfg_rd++;
        if (ctl_req && ctl_we) begin mem_ctl[ctl_addr[3:0]] <= ctl_wdata; n_ctl_wr++; end
        if (ctl_req && !ctl_we) n_ctl_rd++;
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        bit          chk_data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Monitor: compare each access cycle against the scoreboard
    always @(negedge clk) begin
        if (psel && penable) begin
            if (sb.size() == 0) begin
                check(1'b0, "scoreboard empty", 32'(pslverr), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(pslverr === e.err, {e.tag, " pslverr"}, 32'(pslverr), 32'(e.err));
                if (e.chk_data)
                    check(prdata === e.rdata, {e.tag, " prdata"}, prdata, e.rdata);
            end
        end
    end

    task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] er, input bit ee, input string tag);
        exp_t e;
        e.rdata = er; e.err = ee; e.chk_data = !w; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit ee, input string tag);
        xfer(1'b1, a, d, '0, ee, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] er, input bit ee, input string tag);
        xfer(1'b0, a, '0, er, ee, tag);
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int c0, w0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        rd(8'h00, 32'h0, 1'b0, "R11 addr latch");
        rd(8'h08, 32'h0, 1'b0, "R11 control");
        rd(8'h04, 32'h0, 1'b0, "R11 capture");

        // R2/R3 double address write, upper bits dropped
        c0 = n_cfg_rd + n_ctl_rd; w0 = n_cfg_wr + n_ctl_wr;
        wr(8'h00, 32'h0001_0007, 1'b0, "R3 addr write 1");
        wr(8'h00, 32'h0001_0007, 1'b0, "R3 addr write 2");
        check((n_cfg_rd + n_ctl_rd == c0) && (n_cfg_wr + n_ctl_wr == w0), "R3 no request on addr write",
              32'(n_cfg_rd + n_cfg_wr), 32'(c0 + w0));
        rd(8'h00, 32'h0000_0007, 1'b0, "R2 addr low 16 bits");

        // R4/R5 pipelined read
        c0 = n_cfg_rd;
        rd(8'h04, 32'hA000_0000, 1'b0, "R4 stale first read");
        check(n_cfg_rd == c0 + 1, "R4 one internal read", 32'(n_cfg_rd), 32'(c0 + 1));
        rd(8'h04, 32'hA000_0007, 1'b0, "R5 second read fresh");

        // R6 single write forwarded
        w0 = n_cfg_wr;
        wr(8'h04, 32'hDEAD_BEEF, 1'b0, "R6 data write");
        check(n_cfg_wr == w0 + 1, "R6 one internal write", 32'(n_cfg_wr), 32'(w0 + 1));
        check(mem_cfg[7] == 32'hDEAD_BEEF, "R6 target value", mem_cfg[7], 32'hDEAD_BEEF);
        rd(8'h04, 32'hA000_0007, 1'b0, "R6 stale read");
        rd(8'h04, 32'hDEAD_BEEF, 1'b0, "R6 read back");

        // R7 control register keeps only bit 15
        wr(8'h08, 32'hFFFF_FFFF, 1'b0, "R7 control write");
        rd(8'h08, 32'h0000_8000, 1'b0, "R7 control read");

        // R8 boundary in range with enable set
        wr(8'h00, 32'h0000_0FFF, 1'b0, "R8 addr 0FFF");
        wr(8'h00, 32'h0000_0FFF, 1'b0, "R8 addr 0FFF");
        rd(8'h04, 32'hDEAD_BEEF, 1'b0, "R8 boundary stale");
        rd(8'h04, 32'hA000_000F, 1'b0, "R8 boundary in range");

        // R8 out of range with enable set
        wr(8'h00, 32'h0000_1003, 1'b0, "R8 addr 1003");
        w0 = n_cfg_wr; c0 = n_cfg_rd;
        wr(8'h04, 32'h0000_0055, 1'b1, "R8 oor write error");
        rd(8'h04, 32'hA000_000F, 1'b1, "R8 oor read error");
        rd(8'h04, 32'h0000_0000, 1'b1, "R8 oor capture zero");
        check(n_cfg_wr == w0 && n_cfg_rd == c0, "R8 no internal request", 32'(n_cfg_wr + n_cfg_rd), 32'(w0 + c0));
        wr(8'h00, 32'h0000_0003, 1'b0, "R8 addr 3");
        rd(8'h04, 32'h0000_0000, 1'b0, "R8 stale");
        rd(8'h04, 32'hA000_0003, 1'b0, "R8 target untouched");

        // R9 out of range with enable clear
        wr(8'h08, 32'h0000_0000, 1'b0, "R9 disable errors");
        wr(8'h00, 32'h0000_1003, 1'b0, "R9 addr 1003");
        w0 = n_cfg_wr;
        wr(8'h04, 32'h0000_0066, 1'b0, "R9 oor write quiet");
        rd(8'h04, 32'hA000_0003, 1'b0, "R9 oor read quiet");
        rd(8'h04, 32'h0000_0000, 1'b0, "R9 oor capture zero");
        check(n_cfg_wr == w0, "R9 write suppressed", 32'(n_cfg_wr), 32'(w0));
        wr(8'h00, 32'h0000_0003, 1'b0, "R9 addr 3");
        rd(8'h04, 32'h0000_0000, 1'b0, "R9 stale");
        rd(8'h04, 32'hA000_0003, 1'b0, "R9 target untouched");

        // R12 controller window, R8 boundary 0xFFFF
        wr(8'h10, 32'h0000_FFFF, 1'b0, "R12 ctl addr");
        wr(8'h18, 32'h0000_8000, 1'b0, "R12 ctl enable");
        wr(8'h14, 32'h1234_56AB, 1'b1, "R12 wide value refused");
        rd(8'h14, 32'h0000_0000, 1'b0, "R12 ctl stale");
        rd(8'h14, 32'h0000_005F, 1'b0, "R8 ctl FFFF in range");
        wr(8'h18, 32'h0000_0000, 1'b0, "R12 ctl disable");
        wr(8'h14, 32'h1234_56AB, 1'b0, "R12 wide value truncated");
        check(mem_ctl[15] == 8'hAB, "R12 truncated write", 32'(mem_ctl[15]), 32'h0000_00AB);
        rd(8'h14, 32'h0000_005F, 1'b0, "R12 ctl stale 2");
        rd(8'h14, 32'h0000_00AB, 1'b0, "R12 ctl zero extended");

        // R1 independence and unmapped offsets
        rd(8'h00, 32'h0000_0003, 1'b0, "R1 cfg latch independent");
        rd(8'h10, 32'h0000_FFFF, 1'b0, "R1 ctl latch");
        rd(8'h0C, 32'h0, 1'b0, "R1 unmapped 0C");
        rd(8'h1C, 32'h0, 1'b0, "R1 unmapped 1C");
        rd(8'h20, 32'h0, 1'b0, "R1 unmapped 20");
        rd(8'h01, 32'h0, 1'b0, "R1 unaligned");
        wr(8'h20, 32'h0000_0009, 1'b0, "R1 unmapped write");
        rd(8'h00, 32'h0000_0003, 1'b0, "R1 unmapped write no effect");

        // R10 idle response
        @(negedge clk);
        check(pready === 1'b1 && pslverr === 1'b0, "R10 idle ready/no error",
              {30'd0, pready, pslverr}, 32'h2);
        check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule